// File: doc/BRIEF.md
# Fifty-Percent-Duty Load Clock Divider

This block derives a secondary load clock from a fast input clock. It divides the input by one of six moduli (3, 4, 5, 6, 8 or 10). The output stays high for exactly half of its period, including the odd moduli, where the high time ends on a falling edge of the input clock. A 3-bit modulus code and an enable bit select the ratio. Both come from a per-setting configuration table outside the block, so they may change whenever the selected setting changes. The enable, or either of the two spare code values, holds the output at a steady low.

A three-state phase machine clocked on the rising edge runs the output. `PH_OFF` is the suppressed state, with the counter held cleared. `PH_LOW` counts the low phase of an output period. `PH_HIGH` counts the high phase. The transitions are:

- **start** (`PH_OFF`→`PH_LOW`): taken on any edge that sees a runnable setting.
- **rise** (`PH_LOW`→`PH_HIGH`): taken at the end of the low phase when the setting is runnable. This is the only point where a new modulus is latched.
- **park** (`PH_LOW`→`PH_OFF`): taken at the same point when the setting is suppressed.
- **fall** (`PH_HIGH`→`PH_LOW`): taken at the end of the high phase.

For odd moduli, a flop on the falling edge retimes the rising-edge high phase. It is ORed into the output, which adds the missing half input cycle.

Top module: `loadclk_div`

## Requirements
- R1: Codes 3'b001, 3'b011, 3'b100 and 3'b101 with `out_en`=1 select moduli 4, 6, 8 and 10. The output period is N input cycles and its high time is N/2 input cycles.
- R2: Codes 3'b000 and 3'b010 with `out_en`=1 select moduli 3 and 5. The output period is N input cycles and its high time is exactly N/2 input cycles: (N-1)/2 full cycles plus one half cycle that ends on a falling input edge.
- R3: Codes 3'b110 and 3'b111 suppress the output. Once the current period has completed, `div_clk` holds low.
- R4: `out_en`=0 suppresses the output with any code. Once the current period has completed, `div_clk` holds low.
- R5: A code change made during an output period takes effect only at the next rising edge of `div_clk`. The period in progress completes at the old modulus. Every high pulse and every low gap during the change equals N/2 of either the old or the new modulus, so no runt pulse appears.
- R6: From the suppressed state, `div_clk` stays low for ceil(N/2) input cycles, counted from the input rising edge that first samples a runnable setting. Its first edge after that is a rising edge on the next input rising edge.
- R7: An active-low `rst_n` drives `div_clk` low at once, without waiting for a clock edge, and clears the phase machine and its counter.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_in | input | 1 | Fast input clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| mod_code | input | 3 | Modulus code: 000=3, 001=4, 010=5, 011=6, 100=8, 101=10, 110/111=suppress |
| out_en | input | 1 | 1 allows the output to run, 0 suppresses it |
| div_clk | output | 1 | Divided load clock with 50% duty cycle |

## Verification
The bench builds the block with its package defaults: a 3-bit code and a 3-bit phase counter, which covers a phase length of five cycles, the longest the moduli need. At these values the whole code space can be exercised, the two suppress codes included, so every decode entry and both odd ratios are measured at half-cycle resolution. With periods of ten cycles at most, the changes between moduli and the enable latencies fit in short windows, so random setting sequences can reach each transition of the phase machine many times.

// File: rtl/loadclk_pkg.sv
package loadclk_pkg;

    localparam int CODE_W = 3;
    localparam int MOD_W  = 4;
    localparam int LEN_W  = MOD_W - 1;

    typedef enum logic [1:0] {
        PH_OFF  = 2'd0,
        PH_LOW  = 2'd1,
        PH_HIGH = 2'd2
    } phase_e;

    typedef struct packed {
        logic             run;
        logic             odd;
        logic [LEN_W-1:0] hi_len;
        logic [LEN_W-1:0] lo_len;
    } div_cfg_t;

    // Map a modulus code plus enable onto phase lengths.
    // High phase = floor(N/2) cycles, low phase = ceil(N/2) cycles.
    function automatic div_cfg_t decode_mod(input logic [CODE_W-1:0] code,
                                            input logic en);
        logic [MOD_W-1:0] n;
        div_cfg_t c;
        unique case (code)
            3'b000:  n = MOD_W'(3);
            3'b001:  n = MOD_W'(4);
            3'b010:  n = MOD_W'(5);
            3'b011:  n = MOD_W'(6);
            3'b100:  n = MOD_W'(8);
            3'b101:  n = MOD_W'(10);
            default: n = '0;
        endcase
        c.run    = en && (n != '0);
        c.odd    = n[0];
        c.hi_len = LEN_W'(n >> 1);
        c.lo_len = LEN_W'(n - (n >> 1));
        return c;
    endfunction

endpackage

// File: rtl/loadclk_decode.sv
module loadclk_decode
    import loadclk_pkg::*;
(
    input  logic [CODE_W-1:0] code_i,
    input  logic              en_i,
    output div_cfg_t          cfg_o
);

    always_comb begin
        cfg_o = decode_mod(code_i, en_i);
    end

endmodule

// File: rtl/loadclk_phase_fsm.sv
module loadclk_phase_fsm
    import loadclk_pkg::*;
(
    input  logic     clk,
    input  logic     rst_n,
    input  div_cfg_t cfg_in,
    output logic     hi_q,
    output logic     odd_q
);

    phase_e           state, state_nx;
    logic [LEN_W-1:0] cnt, cnt_nx;
    logic [LEN_W-1:0] lo_q;
    logic             load;

    // next-state and counter logic
    always_comb begin
        state_nx = state;
        cnt_nx   = cnt;
        load     = 1'b0;
        unique case (state)
            PH_OFF: begin
                cnt_nx = '0;
                if (cfg_in.run) begin               // start
                    state_nx = PH_LOW;
                    cnt_nx   = cfg_in.lo_len - LEN_W'(1);
                    load     = 1'b1;
                end
            end
            PH_LOW: begin
                if (cnt == '0) begin
                    if (cfg_in.run) begin           // rise
                        state_nx = PH_HIGH;
                        cnt_nx   = cfg_in.hi_len - LEN_W'(1);
                        load     = 1'b1;
                    end else begin                  // park
                        state_nx = PH_OFF;
                        cnt_nx   = '0;
                    end
                end else begin
                    cnt_nx = cnt - LEN_W'(1);
                end
            end
            PH_HIGH: begin
                if (cnt == '0) begin                // fall
                    state_nx = PH_LOW;
                    cnt_nx   = lo_q - LEN_W'(1);
                end else begin
                    cnt_nx = cnt - LEN_W'(1);
                end
            end
            default: begin
                state_nx = PH_OFF;
                cnt_nx   = '0;
            end
        endcase
    end

    // state register, counter and latched setting
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= PH_OFF;
            cnt   <= '0;
            lo_q  <= '0;
            odd_q <= 1'b0;
        end else begin
            state <= state_nx;
            cnt   <= cnt_nx;
            if (load) begin
                lo_q  <= cfg_in.lo_len;
                odd_q <= cfg_in.odd;
            end
        end
    end

    // output register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            hi_q <= 1'b0;
        end else begin
            hi_q <= (state_nx == PH_HIGH);
        end
    end

    // R3: a parked machine cannot raise the output on the next edge
    p_off_quiet_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (state == PH_OFF) |=> !hi_q);

    // R1: the high phase is not cut short while its counter runs
    p_hi_len_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (state == PH_HIGH && cnt != '0) |=> (state == PH_HIGH));

    // R5: the latched setting holds everywhere except at a period boundary
    p_cfg_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (state == PH_HIGH || (state == PH_LOW && cnt != '0)) |=> $stable({lo_q, odd_q}));

    // R6: leaving the suppressed state always passes through the low phase
    p_entry_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (state == PH_OFF) |=> (state == PH_OFF || state == PH_LOW));

endmodule

// File: rtl/loadclk_halfcycle.sv
module loadclk_halfcycle (
    input  logic clk,
    input  logic rst_n,
    input  logic hi_i,
    input  logic odd_i,
    output logic clk_o
);

    logic neg_q;

    // falling-edge copy of the high phase, only for odd moduli
    always_ff @(negedge clk or negedge rst_n) begin
        if (!rst_n) begin
            neg_q <= 1'b0;
        end else begin
            neg_q <= hi_i & odd_i;
        end
    end

    assign clk_o = hi_i | neg_q;

    // R2: the half-cycle extension only trails a live high phase
    p_neg_in_hi_r2: assert property (@(posedge clk) disable iff (!rst_n)
        neg_q |-> hi_i);

    // R2: the extension never appears for an even modulus
    p_neg_odd_r2: assert property (@(posedge clk) disable iff (!rst_n)
        neg_q |-> odd_i);

endmodule

// File: rtl/loadclk_div.sv
module loadclk_div
    import loadclk_pkg::*;
(
    input  logic              clk_in,
    input  logic              rst_n,
    input  logic [CODE_W-1:0] mod_code,
    input  logic              out_en,
    output logic              div_clk
);

    div_cfg_t cfg;
    logic     hi;
    logic     odd;

    loadclk_decode u_decode (
        .code_i (mod_code),
        .en_i   (out_en),
        .cfg_o  (cfg)
    );

    loadclk_phase_fsm u_fsm (
        .clk    (clk_in),
        .rst_n  (rst_n),
        .cfg_in (cfg),
        .hi_q   (hi),
        .odd_q  (odd)
    );

    loadclk_halfcycle u_half (
        .clk    (clk_in),
        .rst_n  (rst_n),
        .hi_i   (hi),
        .odd_i  (odd),
        .clk_o  (div_clk)
    );

endmodule

// File: tb/loadclk_div_tb.sv
module loadclk_div_tb;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [2:0] mod_code = 3'b000;
    logic       out_en = 1'b1;
    logic       div_clk;

    int checks = 0;
    int fails  = 0;

    loadclk_div u_dut (
        .clk_in   (clk),
        .rst_n    (rst_n),
        .mod_code (mod_code),
        .out_en   (out_en),
        .div_clk  (div_clk)
    );

    always #4 clk = ~clk;

    // half-cycle sampler: one sample 1 ns after every input edge
    int  ht = 0, last_rise = 0, last_fall = 0, last_period = 0, last_high = 0;
    int  nrise = 0, hi_cnt = 0, min_high = 1000, min_low = 1000;
    bit  prev = 1'b0, seen_rise = 1'b0, seen_fall = 1'b0;

    always @(posedge clk or negedge clk) begin
        #1;
        ht++;
        if (div_clk && !prev) begin
            if (seen_rise) last_period = ht - last_rise;
            if (seen_fall && (ht - last_fall) < min_low) min_low = ht - last_fall;
            last_rise = ht;
            seen_rise = 1'b1;
            nrise++;
        end
        if (!div_clk && prev && seen_rise) begin
            last_high = ht - last_rise;
            if (last_high < min_high) min_high = last_high;
            last_fall = ht;
            seen_fall = 1'b1;
        end
        if (div_clk) hi_cnt++;
        prev = div_clk;
    end

    function automatic int exp_mod(input logic [2:0] c, input logic e);
        if (!e) return 0;
        case (c)
            3'd0: return 3;
            3'd1: return 4;
            3'd2: return 5;
            3'd3: return 6;
            3'd4: return 8;
            3'd5: return 10;
            default: return 0;
        endcase
    endfunction

    task automatic check(input bit ok, input string req, input int act, input int expv);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, expv);
        end
    endtask

    task automatic apply(input logic [2:0] c, input logic e);
        @(negedge clk);
        mod_code = c;
        out_en   = e;
    endtask

    task automatic cycles(input int n);
        for (int i = 0; i < n; i++) @(posedge clk);
    endtask

    // steady-state period and high time in half cycles
    task automatic measure(input int n, input string req);
        int r;
        r = nrise;
        wait (nrise >= r + 2);
        wait (!div_clk);
        #1;
        check(last_period == 2 * n, {req, " period"}, last_period, 2 * n);
        check(last_high == n, {req, " high time"}, last_high, n);
    endtask

    task automatic check_quiet(input string req);
        cycles(40);
        hi_cnt = 0;
        cycles(40);
        check(hi_cnt == 0, req, hi_cnt, 0);
    endtask

    task automatic enable_latency(input logic [2:0] c);
        int lo;
        lo = (exp_mod(c, 1'b1) + 1) / 2;
        apply(c, 1'b1);
        for (int k = 1; k <= lo; k++) begin
            @(posedge clk); #1;
            check(div_clk == 1'b0, "R6 held low after enable", div_clk, 0);
        end
        @(posedge clk); #1;
        check(div_clk == 1'b1, "R6 first edge rises", div_clk, 1);
    endtask

    task automatic change(input logic [2:0] c_old, input logic [2:0] c_new);
        int r, no, nn;
        no = exp_mod(c_old, 1'b1);
        nn = exp_mod(c_new, 1'b1);
        apply(c_old, 1'b1);
        cycles(40);
        r = nrise;
        wait (nrise != r);
        min_high = 1000;
        min_low  = 1000;
        mod_code = c_new;
        r = nrise;
        wait (nrise != r);
        check(last_period == 2 * no, "R5 period in flight keeps old modulus", last_period, 2 * no);
        r = nrise;
        wait (nrise != r);
        check(last_period == 2 * nn, "R5 next period uses new modulus", last_period, 2 * nn);
        check(min_high == ((no < nn) ? no : nn), "R5 no runt high pulse", min_high, (no < nn) ? no : nn);
        check(min_low == ((no < nn) ? no : nn), "R5 no runt low gap", min_low, (no < nn) ? no : nn);
    endtask

    initial begin
        #(8 * 150000);
        fails++;
        $display("FAIL watchdog actual=hung expected=finished");
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end

    initial begin
        void'($urandom(32'd20240611));
        // R7: reset state
        cycles(3);
        #1;
        check(div_clk == 1'b0, "R7 low in reset", div_clk, 0);
        @(negedge clk);
        rst_n = 1'b1;

        // R1 / R2: every modulus
        for (int c = 0; c < 6; c++) begin
            apply(3'(c), 1'b1);
            cycles(60);
            measure(exp_mod(3'(c), 1'b1), (c == 0 || c == 2) ? "R2" : "R1");
        end

        // R3 / R4: suppression
        apply(3'b110, 1'b1); check_quiet("R3 code 110 quiet");
        apply(3'b111, 1'b1); check_quiet("R3 code 111 quiet");
        apply(3'b011, 1'b0); check_quiet("R4 enable low quiet");

        // R6: latency from suppressed state
        enable_latency(3'b101);
        apply(3'b101, 1'b0); check_quiet("R4 enable low quiet");
        enable_latency(3'b000);
        apply(3'b111, 1'b1); check_quiet("R3 code 111 quiet");
        enable_latency(3'b010);

        // R5: changes between moduli
        change(3'b101, 3'b000);
        change(3'b000, 3'b101);
        change(3'b010, 3'b100);

        // R7: asynchronous reset while high
        wait (div_clk);
        #1;
        rst_n = 1'b0;
        #1;
        check(div_clk == 1'b0, "R7 async reset clears output", div_clk, 0);
        @(negedge clk);
        rst_n = 1'b1;

        // random settings
        for (int i = 0; i < 24; i++) begin
            logic [2:0] c;
            logic       e;
            int         n;
            c = 3'($urandom % 8);
            e = ($urandom % 4) != 0;
            n = exp_mod(c, e);
            apply(c, e);
            cycles(30);
            if (n == 0) begin
                check_quiet(e ? "R3 random suppress" : "R4 random suppress");
            end else begin
                measure(n, n[0] ? "R2 random" : "R1 random");
            end
        end

        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end

endmodule